// File: doc/BRIEF.md
# I2C Register Access Slave

This block is an I2C target that lets a host controller read and write a byte-wide register file through a two-wire bus. The system clock oversamples SCL and SDA. Both lines pass a two-flop synchroniser and a glitch filter before any bus event is decoded. The block answers only to the 7-bit address 60h. When the target drives SDA, it only pulls the line low (open-drain).

A write carries the device address with the write bit, then a register pointer, then one data byte. The first data byte produces a one-cycle write strobe on the register-side bus. Any further bytes are acknowledged and thrown away, because the pointer never increments. A read first sets the pointer the same way. It then issues a repeated start (or a stop and a fresh start), sends the address with the read bit, and receives one byte MSB first. The host ends the read with a NACK.

Pointer values 00h and 01h hold fixed identification bytes. A write aimed at either of them leaves the content unchanged and raises a one-cycle abort pulse instead of a write strobe. An external busy input blocks register writes while it is high, and the bus still sees an acknowledge.

Top module: `i2c_regslave`

## Requirements
- R1: The address byte C0h (address 60h, write) and the address byte C1h (address 60h, read) are acknowledged. For any other 7-bit address the target returns no ACK and keeps SDA released for every byte up to the next start.
- R2: For the sequence start, C0h, pointer P, data D, stop, the target asserts `reg_we_o` for exactly one cycle with `reg_addr_o` = P and `reg_wdata_o` = D. A transaction that ends after the pointer byte produces no strobe.
- R3: When a write carries several data bytes, every byte is acknowledged but only the first one produces a strobe.
- R4: After the pointer is set, a repeated start or a stop-then-start followed by C1h returns the addressed register byte MSB first. After the host's NACK the target releases SDA.
- R5: Pointer 00h reads 1Bh and pointer 01h reads 00h, whatever `reg_rdata_i` presents.
- R6: The first data byte of a write to pointer 00h or 01h is acknowledged. It gives a one-cycle `abort_o` pulse, produces no strobe, and the register still reads its fixed value afterwards.
- R7: While `busy_i` is high when a first data byte completes, no strobe is issued, the byte is still acknowledged, and the register content stays as it was.
- R8: The target changes its SDA drive only while the filtered SCL is low. It holds the ACK from the 8th to the 9th falling SCL edge of a byte, and does not drive during the 8th high phase.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks is ignored. This covers a false SCL edge in the low phase and a false SDA toggle in the high phase.
- R10: After reset the target releases SDA, and `reg_we_o` and `abort_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_i | input | 1 | High blocks register writes |
| reg_addr_o | output | PTR_W | Register pointer |
| reg_wdata_o | output | 8 | Write data for the strobe |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register content at `reg_addr_o` |
| abort_o | output | 1 | One-cycle pulse on a write to an ID register |

## Verification
Four properties are checked on every cycle:
- the write strobe never follows a busy cycle and never targets an ID pointer;
- an abort only targets an ID pointer and never coincides with a strobe;
- the SDA drive only moves after a low SCL sample;
- a filtered line only toggles after its synchronised input has held the new level.

Address matching, pointer retention across a repeated start, discarding of extra data bytes, the ID read values and glitch rejection with data left intact can only be shown by the bench's bus scenarios. The bench sweeps every 7-bit address, writes and reads back every register, and interleaves both read forms.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_ID = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_DATA,
    PH_READ
  } i2cs_phase_t;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int   FILT_LEN  = 3,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN) + 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {2{RESET_VAL}};
      cnt_q  <= '0;
      out_q  <= RESET_VAL;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] != out_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign dout = out_q;

  // R9: the filtered level only moves to a value the synchroniser has held
  a_r9_filter_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_q) |-> ($past(sync_q[1]) == out_q) && ($past(sync_q[1], 2) == out_q));
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h60,
  parameter int         PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_low,
  output logic [PTR_W-1:0]  ptr,
  output logic [BYTE_W-1:0] wdata,
  output logic              we,
  output logic              abort
);
  i2cs_phase_t       phase_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wdata_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              rw_q, first_q, nack_q, we_q, abort_q, oe_q;
  logic [2:0]        bidx;

  assign bidx = 3'd7 - cnt_q[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      nack_q  <= 1'b1;
      we_q    <= 1'b0;
      abort_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      we_q    <= 1'b0;
      abort_q <= 1'b0;
      if (start_det) begin
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt_q < 4'd8) sh_q <= {sh_q[BYTE_W-2:0], sda_f};
          if (cnt_q == 4'd8) nack_q <= sda_f;
          if (cnt_q < 4'd9) cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall) begin
          if (cnt_q == 4'd8) begin
            case (phase_q)
              PH_ADDR: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  oe_q <= 1'b1;
                  rw_q <= sh_q[0];
                end else begin
                  phase_q <= PH_IDLE;
                  oe_q    <= 1'b0;
                end
              end
              PH_PTR: begin
                ptr_q   <= sh_q[PTR_W-1:0];
                first_q <= 1'b1;
                oe_q    <= 1'b1;
              end
              PH_DATA: begin
                oe_q    <= 1'b1;
                first_q <= 1'b0;
                if (first_q) begin
                  if (ptr_q < PTR_W'(NUM_ID)) begin
                    abort_q <= 1'b1;
                  end else if (!busy_i) begin
                    we_q    <= 1'b1;
                    wdata_q <= sh_q;
                  end
                end
              end
              PH_READ: oe_q <= 1'b0;
              default: oe_q <= 1'b0;
            endcase
          end else if (cnt_q == 4'd9) begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
            case (phase_q)
              PH_ADDR: begin
                if (rw_q) begin
                  phase_q <= PH_READ;
                  tx_q    <= rd_byte;
                  oe_q    <= ~rd_byte[7];
                end else begin
                  phase_q <= PH_PTR;
                end
              end
              PH_PTR:  phase_q <= PH_DATA;
              PH_READ: begin
                if (nack_q) begin
                  phase_q <= PH_IDLE;
                end else begin
                  tx_q <= rd_byte;
                  oe_q <= ~rd_byte[7];
                end
              end
              default: phase_q <= phase_q;
            endcase
          end else if (phase_q == PH_READ && cnt_q != 4'd0) begin
            oe_q <= ~tx_q[bidx];
          end
        end
      end
    end
  end

  assign sda_low = oe_q;
  assign ptr     = ptr_q;
  assign wdata   = wdata_q;
  assign we      = we_q;
  assign abort   = abort_q;

  // R7: a strobe only follows a cycle with busy low
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    we_q |-> !$past(busy_i));
  // R6: ID pointers never receive a strobe
  a_r6_no_we_to_id: assert property (@(posedge clk) disable iff (rst)
    we_q |-> (ptr_q >= PTR_W'(NUM_ID)));
  // R6: an abort only names an ID pointer
  a_r6_abort_on_id: assert property (@(posedge clk) disable iff (rst)
    abort_q |-> (ptr_q < PTR_W'(NUM_ID)));
  // R6: strobe and abort never coincide
  a_r6_we_abort_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({we_q, abort_q}));
  // R8: the SDA drive only moves after a low SCL sample
  a_r8_sda_on_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe_q) |-> !$past(scl_f));
  // R1: nothing is driven while the target is idle
  a_r1_idle_release: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) && $stable(phase_q) |-> !oe_q);
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2cs_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR = 7'h60,
  parameter int                FILT_LEN = 3,
  parameter int                PTR_W    = 8,
  parameter logic [BYTE_W-1:0] ID0_VAL  = 8'h1B,
  parameter logic [BYTE_W-1:0] ID1_VAL  = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic              busy_i,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              abort_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_in, filt;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rd_byte;

  assign raw_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cs_glitch_filter #(.FILT_LEN(FILT_LEN), .RESET_VAL(1'b1)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[g]),
      .dout (filt[g])
    );
  end

  i2cs_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (filt[0]),
    .sda_f     (filt[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  always_comb begin
    if (reg_addr_o == PTR_W'(0))      rd_byte = ID0_VAL;
    else if (reg_addr_o == PTR_W'(1)) rd_byte = ID1_VAL;
    else                              rd_byte = reg_rdata_i;
  end

  i2cs_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (filt[0]),
    .sda_f     (filt[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy_i    (busy_i),
    .rd_byte   (rd_byte),
    .sda_low   (sda_low_o),
    .ptr       (reg_addr_o),
    .wdata     (reg_wdata_o),
    .we        (reg_we_o),
    .abort     (abort_o)
  );
endmodule

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;
  localparam int Q    = 12;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic sda_low, reg_we, abort_p;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_low;

  logic [7:0] mem [16] = '{default: 8'hA5};
  assign reg_rdata = mem[reg_addr[3:0]];

  int we_cnt = 0, ab_cnt = 0;
  logic [7:0] last_addr = 8'h00, last_data = 8'h00;
  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr[3:0]] <= reg_wdata;
      we_cnt    <= we_cnt + 1;
      last_addr <= reg_addr;
      last_data <= reg_wdata;
    end
    if (abort_p) ab_cnt <= ab_cnt + 1;
  end

  i2c_regslave u_i2c_regslave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_low_o(sda_low),
    .busy_i(busy), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
    .reg_rdata_i(reg_rdata), .abort_o(abort_p)
  );

  int n_chk = 0, n_bad = 0;
  logic pre_ack_low = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(HOLD);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch) begin
        wt(3); m_scl = 1'b1; wt(2); m_scl = 1'b0; wt(Q - 5);
      end else wt(Q);
      m_scl = 1'b1;
      if (glitch) begin
        wt(4); m_sda = ~b[i]; wt(2); m_sda = b[i]; wt(Q - 6);
      end else begin
        wt(Q / 2);
        if (i == 0) pre_ack_low = sda_low;
        wt(Q - Q / 2);
      end
      m_scl = 1'b0; wt(HOLD);
    end
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q / 2);
    ack = !sda_bus;
    wt(Q - Q / 2); m_scl = 1'b0; wt(HOLD);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); m_scl = 1'b1; wt(Q / 2); b[i] = sda_bus; wt(Q - Q / 2); m_scl = 1'b0; wt(HOLD);
    end
    m_sda = nack; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(HOLD);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d, input bit glitch,
                           output bit all_ack);
    bit k0, k1, k2;
    i2c_start();
    send_byte(8'hC0, 1'b0, k0);
    send_byte(a, 1'b0, k1);
    send_byte(d, glitch, k2);
    i2c_stop();
    all_ack = k0 & k1 & k2;
  endtask

  task automatic reg_read(input logic [7:0] a, input bit via_stop, output logic [7:0] d,
                          output bit all_ack);
    bit k0, k1, k2;
    i2c_start();
    send_byte(8'hC0, 1'b0, k0);
    send_byte(a, 1'b0, k1);
    if (via_stop) i2c_stop();
    i2c_start();
    send_byte(8'hC1, 1'b0, k2);
    recv_byte(1'b1, d);
    i2c_stop();
    all_ack = k0 & k1 & k2;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    bit ok, k;
    int w0, a0;
    wt(8);
    rst = 1'b0;
    wt(4);
    check("R10 sda released", sda_low, 0);
    check("R10 strobe low", reg_we, 0);
    check("R10 abort low", abort_p, 0);

    // R1: every 7-bit address with the write bit
    for (int a = 0; a < 128; a++) begin
      i2c_start();
      send_byte({7'(a), 1'b0}, 1'b0, k);
      check($sformatf("R1 ack addr %0h", a), k, (a == 'h60) ? 1 : 0);
      if (a != 'h60 && (a % 16) == 3) begin
        send_byte(8'h00, 1'b0, k);
        check("R1 released until start", k, 0);
      end
      i2c_stop();
    end

    // R2: write sweep; R8 ack window
    for (int a = 2; a < 16; a++) begin
      w0 = we_cnt;
      reg_write(8'(a), pat(a), 1'b0, ok);
      check("R2 all acked", ok, 1);
      check("R8 no drive in 8th high", pre_ack_low, 0);
      check("R2 one strobe", we_cnt - w0, 1);
      check("R2 strobe addr", last_addr, a);
      check("R2 strobe data", last_data, pat(a));
      check("R8 released after stop", sda_low, 0);
    end

    // R2: pointer only, no data
    w0 = we_cnt;
    i2c_start(); send_byte(8'hC0, 1'b0, k); send_byte(8'h03, 1'b0, k); i2c_stop();
    check("R2 pointer-only no strobe", we_cnt - w0, 0);

    // R4/R5: read sweep, both read forms
    for (int a = 0; a < 16; a++) begin
      reg_read(8'(a), a[0], d, ok);
      check("R1 read address acked", ok, 1);
      check($sformatf("R4 R5 read ptr %0h", a), d,
            (a == 0) ? 'h1B : (a == 1) ? 'h00 : pat(a));
      check("R4 released after nack", sda_low, 0);
    end

    // R3: several data bytes
    w0 = we_cnt;
    i2c_start();
    send_byte(8'hC0, 1'b0, k);
    send_byte(8'h05, 1'b0, k);
    send_byte(8'h11, 1'b0, k); check("R3 first data ack", k, 1);
    send_byte(8'h22, 1'b0, k); check("R3 second data ack", k, 1);
    send_byte(8'h33, 1'b0, k); check("R3 third data ack", k, 1);
    i2c_stop();
    check("R3 single strobe", we_cnt - w0, 1);
    reg_read(8'h05, 1'b0, d, ok);
    check("R3 first byte kept", d, 'h11);

    // R6: writes to the ID registers
    for (int a = 0; a < 2; a++) begin
      w0 = we_cnt; a0 = ab_cnt;
      reg_write(8'(a), 8'h77, 1'b0, ok);
      check("R6 acked", ok, 1);
      check("R6 abort pulse", ab_cnt - a0, 1);
      check("R6 no strobe", we_cnt - w0, 0);
      reg_read(8'(a), 1'b1, d, ok);
      check("R6 id unchanged", d, (a == 0) ? 'h1B : 'h00);
    end

    // R7: busy blocks the write
    busy = 1'b1;
    w0 = we_cnt;
    reg_write(8'h07, 8'hC3, 1'b0, ok);
    check("R7 acked while busy", ok, 1);
    check("R7 no strobe", we_cnt - w0, 0);
    busy = 1'b0;
    reg_read(8'h07, 1'b0, d, ok);
    check("R7 content kept", d, pat(7));
    reg_write(8'h07, 8'hC3, 1'b0, ok);
    reg_read(8'h07, 1'b0, d, ok);
    check("R7 write after busy", d, 'hC3);

    // R9: short glitches on both lines
    w0 = we_cnt;
    reg_write(8'h09, 8'h5A, 1'b1, ok);
    check("R9 acked", ok, 1);
    check("R9 one strobe", we_cnt - w0, 1);
    check("R9 data intact", last_data, 'h5A);
    reg_read(8'h09, 1'b1, d, ok);
    check("R9 read back", d, 'h5A);

    finish_run();
  end
endmodule